// File: doc/BRIEF.md
# SPI Controller with Mode Fault

This block is a byte-wide serial peripheral port that can act either as the clock-generating master or as a selected slave. A CPU sets it up through a small register bus. The bus has three addresses: an 8-bit control register, a status register and a data register. One enable bit in the control register decides whether the block drives the serial pins or leaves them alone. As master, a write to the data register starts an 8-bit exchange. The serial clock is derived from the system clock with one of six rates, and its idle level and capture phase are selectable. As slave, the serial clock comes from the pin. The block answers when the select input is low.

Each exchange moves the most significant bit first. When the eighth bit has been captured, a done flag is raised. The received byte can then be read back. The select input can be pulled low while the block is master. Hardware treats this as a conflict on the bus: it drops both the enable and the master bits and raises a fault flag. An interrupt request combines the two flags under an enable bit. The CPU clears a flag in two steps. It first reads the status register and then accesses the control or data register.

A single state machine in `spi_mf_engine` drives both roles. Its states are `ST_IDLE`, `ST_MASTER`, `ST_SLAVE` and `ST_SLAVE_HOLD`, with these transitions:
- `ST_IDLE` → `ST_MASTER`: a data write while enabled as master.
- `ST_IDLE` → `ST_SLAVE`: selected while enabled as slave.
- `ST_MASTER` → `ST_IDLE`: after the sixteenth clock edge, or when enable or master drops.
- `ST_SLAVE` → `ST_SLAVE_HOLD`: after the sixteenth pin edge.
- `ST_SLAVE` → `ST_IDLE` and `ST_SLAVE_HOLD` → `ST_IDLE`: when select rises, or when enable drops, or when master is set.

Top module: `spi_mf_ctrl`

## Requirements
- R1: The control register sits at bus address 0 and resets to 0x00. Its bits are: bit 7 interrupt enable, bit 6 port enable, bit 5 divide-by-2 bypass, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate field. It reads back as written.
- R2: With port enable at 0, sck_oe, mosi_oe and miso_oe are all 0. With enable and master set, sck_oe and mosi_oe are 1 and miso_oe is 0. With enable set, master clear and ss_n low, only miso_oe is 1.
- R3: In master mode, {bypass, rate} sets the serial clock period in system clocks: 100→4, 000→8, 001→16, 110→32, 010→64, 011→128. Codes 101 and 111 give 8 and 64.
- R4: While no master transfer is running and the block owns the pins as master, sck_out equals the polarity bit.
- R5: A transfer moves 8 bits MSB first. With phase 0, data is captured on odd serial clock edges. With phase 1, it is captured on even edges. The done flag (status bit 7, bus address 1) sets on the eighth capture. In master mode that is 15 or 16 half-periods after the data write, for phase 0 or 1. A read of bus address 2 returns the received byte. A master transfer starts on a write to address 2 while enabled as master and idle.
- R6: In slave mode the serial clock is taken from sck_in and the rate bits have no effect. As soon as the select is seen low, miso_out presents bit 7 of the last byte written to address 2, before any clock edge.
- R7: If enable and master are both 1 and the synchronised ss_n is low, the next clock edge clears enable and master and sets the fault flag (status bit 6).
- R8: irq is 1 exactly when interrupt enable is 1 and the done or fault flag is set.
- R9: A flag is cleared only by a status read that saw it set, followed by an access to address 0 or 2. An access to address 0 or 2 without a prior status read leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from pin (slave) |
| sck_out | output | 1 | Serial clock to pin (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_in | input | 1 | Master-out line sampled as slave |
| mosi_out | output | 1 | Master-out line driven as master |
| mosi_oe | output | 1 | Master-out drive enable |
| miso_in | input | 1 | Slave-out line sampled as master |
| miso_out | output | 1 | Slave-out line driven as slave |
| miso_oe | output | 1 | Slave-out drive enable |
| ss_n | input | 1 | Active-low select / fault sense |

## Verification
The assertions rely on three facts about the inputs:
- Register accesses are single-cycle strobes.
- ss_n stays high during master transfers, except in the deliberate fault case.
- In slave mode the pin clock runs well below the system clock, so a fixed 16-cycle half-period is seen through the two-stage synchroniser.

The stimulus keeps to these limits. It changes the pin data only on launch edges, and it loops the master output back inverted to the master input, so that every received byte differs from the byte sent.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MASTER,
        ST_SLAVE,
        ST_SLAVE_HOLD
    } eng_state_t;

    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       div2_off;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
    parameter int unsigned    W       = 3,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_mf_rate.sv
module spi_mf_rate #(
    parameter int unsigned MAX_HALF_LOG = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       div2_off,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int unsigned CNT_W = MAX_HALF_LOG + 1;

    logic [3:0]       base_log;
    logic [3:0]       half_log;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    // full period = 2**base_log, halved when the bypass bit is set
    always_comb begin
        unique case (rate)
            2'd0: base_log = 4'd3;
            2'd1: base_log = 4'd4;
            2'd2: base_log = 4'd6;
            2'd3: base_log = 4'd7;
        endcase
        half_log = base_log - 4'd1 - {3'b000, div2_off};
        limit    = (CNT_W'(1) << half_log) - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run)           cnt <= '0;
        else if (cnt == limit)   cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end

    assign tick = run && (cnt == limit);

endmodule

// File: rtl/spi_mf_engine.sv
module spi_mf_engine
    import spi_mf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              cpha,
    input  logic              mst_tick,
    input  logic              sck_edge,
    input  logic              ss_active,
    input  logic              start,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              miso_in,
    input  logic              mosi_in,
    output eng_state_t        state_o,
    output logic              sck_ph,
    output logic              out_bit,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_strobe
);

    localparam int unsigned EDGES = 2 * DATA_W;
    localparam int unsigned EC_W  = $clog2(EDGES + 1);

    eng_state_t        state_q, state_d;
    logic [EC_W-1:0]   ecnt;
    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic              edge_ev, leading, capture_ev, launch_ev;
    logic              last_cap, final_edge, in_bit, enter, leave;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en && master && start)          state_d = ST_MASTER;
                else if (en && !master && ss_active) state_d = ST_SLAVE;
            end
            ST_MASTER: begin
                if (!en || !master)   state_d = ST_IDLE;
                else if (final_edge)  state_d = ST_IDLE;
            end
            ST_SLAVE: begin
                if (!en || master || !ss_active) state_d = ST_IDLE;
                else if (final_edge)             state_d = ST_SLAVE_HOLD;
            end
            ST_SLAVE_HOLD: begin
                if (!en || master || !ss_active) state_d = ST_IDLE;
            end
        endcase
    end

    // edge classification
    always_comb begin
        unique case (state_q)
            ST_MASTER: edge_ev = mst_tick;
            ST_SLAVE:  edge_ev = sck_edge;
            default:   edge_ev = 1'b0;
        endcase
        leading    = !ecnt[0];
        capture_ev = edge_ev && (leading ^ cpha);
        launch_ev  = edge_ev && !(leading ^ cpha);
        last_cap   = capture_ev && (ecnt == (EC_W'(EDGES - 2) + EC_W'(cpha)));
        final_edge = edge_ev && (ecnt == EC_W'(EDGES - 1));
        in_bit     = (state_q == ST_MASTER) ? miso_in : mosi_in;
        enter      = (state_q == ST_IDLE) && (state_d != ST_IDLE);
        leave      = (state_q != ST_IDLE) && (state_d == ST_IDLE);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt    <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
            out_bit <= 1'b0;
            sck_ph  <= 1'b0;
        end else if (enter) begin
            ecnt    <= '0;
            sck_ph  <= 1'b0;
            out_bit <= load_byte[DATA_W-1];
            tx_sh   <= cpha ? load_byte : (load_byte << 1);
        end else begin
            if (edge_ev) begin
                ecnt   <= ecnt + EC_W'(1);
                sck_ph <= ~sck_ph;
            end
            if (capture_ev) rx_sh <= {rx_sh[DATA_W-2:0], in_bit};
            if (last_cap)   rx_byte <= {rx_sh[DATA_W-2:0], in_bit};
            if (launch_ev) begin
                out_bit <= tx_sh[DATA_W-1];
                tx_sh   <= tx_sh << 1;
            end
            if (leave) sck_ph <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        rx_strobe = last_cap && en;
    end

endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
    import spi_mf_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned MAX_HALF_LOG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              ss_n
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] tx_buf, rx_byte, load_byte;
    logic              ss_s_n, sck_s, mosi_s, sck_prev, sck_edge;
    logic              wr_ctrl, wr_data, rd_stat, clr_acc, fault_ev;
    logic              done_q, fault_q, arm_done, arm_fault;
    logic              mst_tick, sck_ph, out_bit, rx_strobe;
    eng_state_t        eng_state;

    spi_mf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n, sck_in, mosi_in}),
        .q     ({ss_s_n, sck_s, mosi_s})
    );

    spi_mf_rate #(.MAX_HALF_LOG(MAX_HALF_LOG)) i_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_state == ST_MASTER),
        .div2_off (ctrl_q.div2_off),
        .rate     (ctrl_q.rate),
        .tick     (mst_tick)
    );

    spi_mf_engine #(.DATA_W(DATA_W)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_q.enable),
        .master    (ctrl_q.master),
        .cpha      (ctrl_q.cpha),
        .mst_tick  (mst_tick),
        .sck_edge  (sck_edge),
        .ss_active (!ss_s_n),
        .start     (wr_data),
        .load_byte (load_byte),
        .miso_in   (miso_in),
        .mosi_in   (mosi_s),
        .state_o   (eng_state),
        .sck_ph    (sck_ph),
        .out_bit   (out_bit),
        .rx_byte   (rx_byte),
        .rx_strobe (rx_strobe)
    );

    always_comb begin
        wr_ctrl   = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
        wr_data   = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
        rd_stat   = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);
        clr_acc   = bus_sel && ((bus_addr == ADDR_CTRL) || (bus_addr == ADDR_DATA));
        fault_ev  = ctrl_q.enable && ctrl_q.master && !ss_s_n;
        sck_edge  = sck_s ^ sck_prev;
        load_byte = wr_data ? bus_wdata : tx_buf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            tx_buf    <= '0;
            sck_prev  <= 1'b0;
            done_q    <= 1'b0;
            fault_q   <= 1'b0;
            arm_done  <= 1'b0;
            arm_fault <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[7:0]);
            if (fault_ev) begin
                ctrl_q.enable <= 1'b0;
                ctrl_q.master <= 1'b0;
            end
            if (wr_data) tx_buf <= bus_wdata;

            if (rd_stat) begin
                arm_done  <= done_q;
                arm_fault <= fault_q;
            end else if (clr_acc) begin
                arm_done  <= 1'b0;
                arm_fault <= 1'b0;
            end

            if (rx_strobe)                 done_q <= 1'b1;
            else if (clr_acc && arm_done)  done_q <= 1'b0;

            if (fault_ev)                  fault_q <= 1'b1;
            else if (clr_acc && arm_fault) fault_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        irq      = ctrl_q.irq_en && (done_q || fault_q);
        sck_oe   = ctrl_q.enable && ctrl_q.master;
        mosi_oe  = ctrl_q.enable && ctrl_q.master;
        miso_oe  = ctrl_q.enable && !ctrl_q.master && !ss_s_n;
        sck_out  = ctrl_q.cpol ^ sck_ph;
        mosi_out = out_bit;
        miso_out = (eng_state == ST_IDLE) ? tx_buf[DATA_W-1] : out_bit;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
            ADDR_STAT: bus_rdata = DATA_W'({done_q, fault_q, 6'b000000});
            ADDR_DATA: bus_rdata = rx_byte;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_mf_checker.sv
module spi_mf_checker
    import spi_mf_pkg::*;
#(
    parameter int unsigned MAX_HALF_LOG = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       spe,
    input logic       mstr,
    input logic       spie,
    input logic       cpol,
    input logic       ss_s_n,
    input logic       done,
    input logic       fault,
    input logic       arm_done,
    input logic       clr_acc,
    input logic       rx_strobe,
    input logic       irq,
    input logic       sck_out,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe,
    input eng_state_t eng_state
);

    localparam int unsigned MAX_HOLD = 1 << MAX_HALF_LOG;
    localparam int unsigned HC_W     = MAX_HALF_LOG + 2;

    logic [HC_W-1:0] hold_cnt;
    logic            sck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_last <= sck_out;
            if (eng_state != ST_MASTER || sck_out != sck_last) hold_cnt <= '0;
            else                                               hold_cnt <= hold_cnt + HC_W'(1);
        end
    end

    assert_pins_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !spe |-> (!sck_oe && !mosi_oe && !miso_oe));

    assert_dir_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mosi_oe && miso_oe));

    assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= HC_W'(MAX_HOLD));

    assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_IDLE && sck_oe) |-> (sck_out == cpol));

    assert_fault_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spe && mstr && !ss_s_n) |=> (!spe && !mstr && fault));

    assert_done_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && spie) |-> irq);

    assert_quiet_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !fault) |-> !irq);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_done && clr_acc && !rx_strobe) |=> !done);

endmodule

bind spi_mf_ctrl spi_mf_checker #(.MAX_HALF_LOG(MAX_HALF_LOG)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spe       (ctrl_q.enable),
    .mstr      (ctrl_q.master),
    .spie      (ctrl_q.irq_en),
    .cpol      (ctrl_q.cpol),
    .ss_s_n    (ss_s_n),
    .done      (done_q),
    .fault     (fault_q),
    .arm_done  (arm_done),
    .clr_acc   (clr_acc),
    .rx_strobe (rx_strobe),
    .irq       (irq),
    .sck_out   (sck_out),
    .sck_oe    (sck_oe),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .eng_state (eng_state)
);

// File: tb/test_spi_mf_ctrl.sv
module test_spi_mf_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {control byte, byte sent, cycles from data write to done}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'hF0, 8'hA5, 16'd30},
        {8'hD8, 8'h3C, 16'd60},
        {8'hD5, 8'hC3, 16'd128},
        {8'hFE, 8'h5A, 16'd256},
        {8'hD2, 8'h0F, 16'd480},
        {8'hDB, 8'hE1, 16'd960}
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic       irq, sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
    logic       sck_in = 1'b0, mosi_in = 1'b0, ss_n = 1'b1;
    logic       miso_in;
    int         checks = 0, fails = 0;

    assign miso_in = ~mosi_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_mf_ctrl i_spi_mf_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe), .ss_n(ss_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic slave_xfer(input logic [7:0] ctrl, input logic [7:0] txb, input logic [7:0] rxb);
        logic [7:0] got, rd;
        got = 8'h00;
        sck_in = ctrl[3]; mosi_in = 1'b0; ss_n = 1'b1;
        bus_write(2'd0, ctrl);
        bus_write(2'd2, txb);
        repeat (4) @(negedge clk);
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 slave owns miso", {31'd0, miso_oe}, 32'd1);
        chk("R6 first bit before clock", {31'd0, miso_out}, {31'd0, txb[7]});
        for (int i = 7; i >= 0; i--) begin
            if (!ctrl[2]) begin
                mosi_in = rxb[i];
                repeat (16) @(negedge clk);
                got = {got[6:0], miso_out};
                sck_in = ~sck_in;
                repeat (16) @(negedge clk);
                sck_in = ~sck_in;
            end else begin
                sck_in = ~sck_in;
                mosi_in = rxb[i];
                repeat (16) @(negedge clk);
                got = {got[6:0], miso_out};
                sck_in = ~sck_in;
                repeat (16) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
        chk("R6 slave sends MSB first", {24'd0, got}, {24'd0, txb});
        bus_read(2'd1, rd);
        chk("R5 slave done flag", {24'd0, rd}, 32'h80);
        bus_read(2'd2, rd);
        chk("R5 slave received byte", {24'd0, rd}, {24'd0, rxb});
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(2'd1, rd);
        chk("R9 slave flag cleared", {24'd0, rd}, 32'h00);
        chk("R2 miso released", {31'd0, miso_oe}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        bus_read(2'd0, rd);
        chk("R1 control reset", {24'd0, rd}, 32'h00);
        bus_read(2'd1, rd);
        chk("R5 status reset", {24'd0, rd}, 32'h00);
        chk("R8 irq after reset", {31'd0, irq}, 32'd0);
        chk("R2 pins released at reset", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd0);
        bus_write(2'd0, 8'h4C);
        bus_read(2'd0, rd);
        chk("R1 control readback", {24'd0, rd}, 32'h4C);
        chk("R2 slave unselected", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd0);
        bus_write(2'd0, 8'h00);

        // master transfers over every rate code
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] c, t;
            c = VEC[v][31:24];
            t = VEC[v][23:16];
            bus_write(2'd0, c);
            chk("R2 master owns sck and mosi", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd6);
            chk("R4 idle level before transfer", {31'd0, sck_out}, {31'd0, c[3]});
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = t;
            @(posedge clk);
            #1 bus_sel = 1'b0; bus_wr = 1'b0;
            n = 0;
            while (n < 5000) begin
                @(posedge clk);
                n++;
                #1;
                if (irq) break;
            end
            chk("R3 R5 cycles to done", n, {16'd0, VEC[v][15:0]});
            repeat (200) @(negedge clk);
            chk("R4 idle level after transfer", {31'd0, sck_out}, {31'd0, c[3]});
            bus_read(2'd1, rd);
            chk("R5 done flag", {24'd0, rd}, 32'h80);
            bus_read(2'd2, rd);
            chk("R5 received byte MSB first", {24'd0, rd}, {24'd0, ~t});
            bus_read(2'd1, rd);
            chk("R9 flag cleared", {24'd0, rd}, 32'h00);
        end

        // interrupt masked, and clearing needs a prior status read
        bus_write(2'd0, 8'h50);
        bus_write(2'd2, 8'h81);
        repeat (90) @(negedge clk);
        chk("R8 irq masked", {31'd0, irq}, 32'd0);
        bus_read(2'd2, rd);
        chk("R5 received with irq masked", {24'd0, rd}, 32'h7E);
        bus_read(2'd1, rd);
        chk("R9 no clear without status read", {24'd0, rd}, 32'h80);
        bus_write(2'd0, 8'h00);
        bus_read(2'd1, rd);
        chk("R9 cleared by control access", {24'd0, rd}, 32'h00);

        // slave role, rate bits set differently each time
        slave_xfer(8'hC3, 8'h96, 8'h5A);
        slave_xfer(8'hEC, 8'h2D, 8'hB4);

        // mode fault
        bus_write(2'd0, 8'hD0);
        @(negedge clk);
        ss_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 fault releases sck", {31'd0, sck_oe}, 32'd0);
        bus_read(2'd0, rd);
        chk("R7 fault clears enable and master", {24'd0, rd}, 32'h80);
        chk("R8 irq on fault", {31'd0, irq}, 32'd1);
        bus_read(2'd1, rd);
        chk("R7 fault flag", {24'd0, rd}, 32'h40);
        ss_n = 1'b1;
        bus_write(2'd0, 8'h00);
        bus_read(2'd1, rd);
        chk("R9 fault cleared", {24'd0, rd}, 32'h00);
        chk("R8 irq low after clear", {31'd0, irq}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule